// File: doc/BRIEF.md
# Quad-Channel Codec Control Decoder

This block holds the programming state of a four-channel voice codec. A serial control port has already been turned into bytes. Each byte arrives on `byte_data` together with a one-cycle `byte_valid` strobe.

A command is one configuration byte. Some configuration bytes are followed by one data byte. The configuration byte does three things:
- It picks a mode.
- It addresses one channel.
- It says how the next data byte is to be read. That data byte can be a time-slot number, a SLIC pin image, or one half of a gain coefficient.

The outputs are the global companding law and frame timing, and for each channel: the receive and transmit enables and slot numbers, the I/O pin directions, the pin levels with their output enables, and two 14-bit gain coefficients. Every accepted byte updates the state at the clock edge where it is taken. The new value is visible on the outputs in the following cycle.

Top module: `codec_ctl_decoder`

## Requirements
- R1: Bit 7 of a byte gives its kind: 1 is a configuration byte and 0 is a data byte. A data byte is consumed only when a configuration byte has left one pending, and at most one data byte is consumed per configuration byte. Any other data byte changes nothing.
- R2: For a configuration byte with bits 6:5 = 00 or 01 (codec mode), `law_alaw` takes bit 5. The value 0 selects µ-law and 1 selects A-law, for all channels.
- R3: In codec mode, `frame_delay` takes bit 4 of the configuration byte. The value 0 is non-delay timing and 1 is delay timing. Configuration bytes in any other mode leave `frame_delay` unchanged.
- R4: In codec mode, bits 3:2 address a channel. For that channel, `rx_on` takes bit 0 and `tx_on` takes bit 1. A non-zero code leaves a slot data byte pending. Code 00 powers the channel down and leaves nothing pending.
- R5: A pending slot data byte writes its bits 6:0 into `rx_slot` of the latched channel if the receive enable was requested. It writes the same value into `tx_slot` if the transmit enable was requested. The other slot is left unchanged.
- R6: A configuration byte with bits 6:4 = 101 (SLIC mode) sets the I/O directions of the addressed channel from bits 1:0. Bit 0 controls I/O pin 0 and bit 1 controls I/O pin 1, and a 1 means input. This byte leaves a SLIC data byte pending.
- R7: A pending SLIC data byte stores its bits 4:0 as the channel pin image, and bits 6:5 are ignored. In each 5-bit pin field, bits 0 and 1 are the I/O pins and bits 4:2 are the output-only pins. `pin_oe` is 1 on bits 4:2 and is the inverse of the direction on bits 1:0. `pin_level` is the stored image masked by `pin_oe`.
- R8: A configuration byte with bits 6:4 = 100 (gain mode) leaves a gain data byte pending. Bit 1 selects the transmit coefficient (1) or the receive coefficient (0). Bit 0 selects the upper half (1) or the lower half (0). The data byte's bits 6:0 are written to coefficient bits 13:7 for the upper half and bits 6:0 for the lower half, and the other half is kept.
- R9: A configuration byte with bits 6:5 = 11 changes no output and cancels any pending data byte.
- R10: A configuration byte that arrives while a data byte is pending replaces the pending command. The later data byte then follows the newer configuration.
- R11: Synchronous reset has the following effects:
  - It clears all enables, the slots and the gains.
  - It selects µ-law and non-delay timing.
  - It makes every I/O pin an input, so `pin_oe` reads 5'b11100 for each channel.
  - It clears anything pending.
- R12: While `byte_valid` is low, no output changes, whatever is on `byte_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | `byte_data` holds a byte this cycle |
| byte_data | input | 8 | Control byte |
| law_alaw | output | 1 | 0 µ-law, 1 A-law |
| frame_delay | output | 1 | 0 non-delay, 1 delay timing |
| rx_on | output | NCH | Receive enable per channel |
| tx_on | output | NCH | Transmit enable per channel |
| rx_slot | output | NCH*7 | Receive slot per channel, channel n at bits 7n+:7 |
| tx_slot | output | NCH*7 | Transmit slot per channel |
| io_is_input | output | NCH*2 | I/O pin direction per channel, 1 = input |
| pin_level | output | NCH*5 | Pin values per channel, masked by enable |
| pin_oe | output | NCH*5 | Pin output enables per channel |
| rx_gain | output | NCH*14 | Receive gain coefficient per channel |
| tx_gain | output | NCH*14 | Transmit gain coefficient per channel |

## Verification
The hardest states to reach from the ports involve the pending-byte state, which no output shows. Three cases matter:
- a stray data byte arriving after a command that needed none;
- a second data byte arriving after one has already been consumed;
- a reserved-mode byte or a new configuration byte arriving between a configuration byte and its data byte.

Each case is provoked by a directed byte order in the vector table. The result is then read from a slot or gain output that a wrongly consumed byte would have overwritten. Values already present there, such as slot 21, make an unwanted write visible.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam int ADDR_W = 2;   // channel address field width
  localparam int SLOT_W = 7;   // slot number width
  localparam int HALF_W = 7;   // gain coefficient half width
  localparam int GAIN_W = 2 * HALF_W;
  localparam int PIN_N  = 5;   // pins per channel
  localparam int IO_N   = 2;   // bidirectional pins per channel

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_SLOT,
    PEND_SLIC,
    PEND_GAIN
  } pend_e;

  typedef struct packed {
    logic              cfg_we;
    logic              rx_on;
    logic              tx_on;
    logic              slot_we;
    logic              slot_rx;
    logic              slot_tx;
    logic              dir_we;
    logic [IO_N-1:0]   dir;
    logic              img_we;
    logic [PIN_N-1:0]  img;
    logic              gain_we;
    logic              gain_tx;
    logic              gain_hi;
    logic [HALF_W-1:0] val;
  } chan_wr_t;
endpackage

// File: rtl/ccd_cmd_decode.sv
module ccd_cmd_decode
  import ccd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output chan_wr_t          wr,
  output logic [ADDR_W-1:0] wr_ch,
  output logic              law_alaw,
  output logic              frame_delay
);
  pend_e             pend_q, pend_d;
  logic [ADDR_W-1:0] pch_q, pch_d;
  logic              prx_q, prx_d, ptx_q, ptx_d;
  logic              ghi_q, ghi_d;

  logic       is_cfg;
  logic [1:0] mode;
  assign is_cfg = byte_data[7];
  assign mode   = byte_data[6:5];

  always_comb begin
    wr     = '0;
    wr_ch  = byte_data[3:2];
    pend_d = pend_q;
    pch_d  = pch_q;
    prx_d  = prx_q;
    ptx_d  = ptx_q;
    ghi_d  = ghi_q;
    if (byte_valid) begin
      if (is_cfg) begin
        pend_d = PEND_NONE;
        pch_d  = byte_data[3:2];
        unique case (mode)
          2'b00, 2'b01: begin
            wr.cfg_we = 1'b1;
            wr.rx_on  = byte_data[0];
            wr.tx_on  = byte_data[1];
            prx_d     = byte_data[0];
            ptx_d     = byte_data[1];
            if (|byte_data[1:0]) pend_d = PEND_SLOT;
          end
          2'b10: begin
            if (byte_data[4]) begin
              wr.dir_we = 1'b1;
              wr.dir    = byte_data[1:0];
              pend_d    = PEND_SLIC;
            end else begin
              ptx_d  = byte_data[1];
              ghi_d  = byte_data[0];
              pend_d = PEND_GAIN;
            end
          end
          default: ;
        endcase
      end else begin
        wr_ch  = pch_q;
        wr.val = byte_data[HALF_W-1:0];
        pend_d = PEND_NONE;
        unique case (pend_q)
          PEND_SLOT: begin
            wr.slot_we = 1'b1;
            wr.slot_rx = prx_q;
            wr.slot_tx = ptx_q;
          end
          PEND_SLIC: begin
            wr.img_we = 1'b1;
            wr.img    = byte_data[PIN_N-1:0];
          end
          PEND_GAIN: begin
            wr.gain_we = 1'b1;
            wr.gain_tx = ptx_q;
            wr.gain_hi = ghi_q;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= PEND_NONE;
      pch_q       <= '0;
      prx_q       <= 1'b0;
      ptx_q       <= 1'b0;
      ghi_q       <= 1'b0;
      law_alaw    <= 1'b0;
      frame_delay <= 1'b0;
    end else begin
      pend_q <= pend_d;
      pch_q  <= pch_d;
      prx_q  <= prx_d;
      ptx_q  <= ptx_d;
      ghi_q  <= ghi_d;
      if (byte_valid && is_cfg && !byte_data[6]) begin
        law_alaw    <= byte_data[5];
        frame_delay <= byte_data[4];
      end
    end
  end
endmodule

// File: rtl/ccd_chan_regs.sv
module ccd_chan_regs
  import ccd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  chan_wr_t          wr,
  output logic              rx_on,
  output logic              tx_on,
  output logic [SLOT_W-1:0] rx_slot,
  output logic [SLOT_W-1:0] tx_slot,
  output logic [IO_N-1:0]   io_in,
  output logic [PIN_N-1:0]  pin_level,
  output logic [PIN_N-1:0]  pin_oe,
  output logic [GAIN_W-1:0] rx_gain,
  output logic [GAIN_W-1:0] tx_gain
);
  logic [PIN_N-1:0] img_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_on   <= 1'b0;
      tx_on   <= 1'b0;
      rx_slot <= '0;
      tx_slot <= '0;
      io_in   <= '1;
      img_q   <= '0;
      rx_gain <= '0;
      tx_gain <= '0;
    end else if (sel) begin
      if (wr.cfg_we) begin
        rx_on <= wr.rx_on;
        tx_on <= wr.tx_on;
      end
      if (wr.slot_we && wr.slot_rx) rx_slot <= wr.val[SLOT_W-1:0];
      if (wr.slot_we && wr.slot_tx) tx_slot <= wr.val[SLOT_W-1:0];
      if (wr.dir_we) io_in <= wr.dir;
      if (wr.img_we) img_q <= wr.img;
      if (wr.gain_we) begin
        if (wr.gain_tx) begin
          if (wr.gain_hi) tx_gain[GAIN_W-1:HALF_W] <= wr.val;
          else            tx_gain[HALF_W-1:0]      <= wr.val;
        end else begin
          if (wr.gain_hi) rx_gain[GAIN_W-1:HALF_W] <= wr.val;
          else            rx_gain[HALF_W-1:0]      <= wr.val;
        end
      end
    end
  end

  assign pin_oe    = {{(PIN_N-IO_N){1'b1}}, ~io_in};
  assign pin_level = img_q & pin_oe;
endmodule

// File: rtl/codec_ctl_decoder.sv
module codec_ctl_decoder
  import ccd_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    byte_valid,
  input  logic [7:0]              byte_data,
  output logic                    law_alaw,
  output logic                    frame_delay,
  output logic [NCH-1:0]          rx_on,
  output logic [NCH-1:0]          tx_on,
  output logic [NCH*SLOT_W-1:0]   rx_slot,
  output logic [NCH*SLOT_W-1:0]   tx_slot,
  output logic [NCH*IO_N-1:0]     io_is_input,
  output logic [NCH*PIN_N-1:0]    pin_level,
  output logic [NCH*PIN_N-1:0]    pin_oe,
  output logic [NCH*GAIN_W-1:0]   rx_gain,
  output logic [NCH*GAIN_W-1:0]   tx_gain
);
  chan_wr_t          wr;
  logic [ADDR_W-1:0] wr_ch;

  ccd_cmd_decode u_dec (
    .clk         (clk),
    .rst         (rst),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .wr          (wr),
    .wr_ch       (wr_ch),
    .law_alaw    (law_alaw),
    .frame_delay (frame_delay)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    ccd_chan_regs u_regs (
      .clk       (clk),
      .rst       (rst),
      .sel       (wr_ch == ADDR_W'(ch)),
      .wr        (wr),
      .rx_on     (rx_on[ch]),
      .tx_on     (tx_on[ch]),
      .rx_slot   (rx_slot[ch*SLOT_W +: SLOT_W]),
      .tx_slot   (tx_slot[ch*SLOT_W +: SLOT_W]),
      .io_in     (io_is_input[ch*IO_N +: IO_N]),
      .pin_level (pin_level[ch*PIN_N +: PIN_N]),
      .pin_oe    (pin_oe[ch*PIN_N +: PIN_N]),
      .rx_gain   (rx_gain[ch*GAIN_W +: GAIN_W]),
      .tx_gain   (tx_gain[ch*GAIN_W +: GAIN_W])
    );
  end
endmodule

// File: rtl/ccd_checker.sv
module ccd_checker
  import ccd_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  byte_valid,
  input logic [7:0]            byte_data,
  input logic                  law_alaw,
  input logic                  frame_delay,
  input logic [NCH-1:0]        rx_on,
  input logic [NCH-1:0]        tx_on,
  input logic [NCH*SLOT_W-1:0] rx_slot,
  input logic [NCH*SLOT_W-1:0] tx_slot,
  input logic [NCH*IO_N-1:0]   io_is_input,
  input logic [NCH*PIN_N-1:0]  pin_level,
  input logic [NCH*PIN_N-1:0]  pin_oe,
  input logic [NCH*GAIN_W-1:0] rx_gain,
  input logic [NCH*GAIN_W-1:0] tx_gain
);
  logic [2+2*NCH+2*NCH*SLOT_W+NCH*IO_N+2*NCH*PIN_N+2*NCH*GAIN_W-1:0] all_out;
  assign all_out = {law_alaw, frame_delay, rx_on, tx_on, rx_slot, tx_slot,
                    io_is_input, pin_level, pin_oe, rx_gain, tx_gain};

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |=> $stable(all_out)); // R12

  AST_LAW_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_data[7] && !byte_data[6]) |=> (law_alaw == $past(byte_data[5]))); // R2

  AST_TIMING_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_data[7] && !byte_data[6]) |=> (frame_delay == $past(byte_data[4]))); // R3

  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_data[7:5] == 3'b111) |=> $stable(all_out)); // R9

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (rx_on == '0 && tx_on == '0 && !law_alaw && !frame_delay && io_is_input == '1)); // R11
endmodule

bind codec_ctl_decoder ccd_checker #(.NCH(NCH)) u_ccd_checker (.*);

// File: tb/test_codec_ctl_decoder.sv
module test_codec_ctl_decoder;
  localparam int NCH = 4;
  localparam int NV  = 29;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic law_alaw, frame_delay;
  logic [NCH-1:0] rx_on, tx_on;
  logic [NCH*7-1:0] rx_slot, tx_slot;
  logic [NCH*2-1:0] io_is_input;
  logic [NCH*5-1:0] pin_level, pin_oe;
  logic [NCH*14-1:0] rx_gain, tx_gain;

  always #2.5 clk = ~clk;

  codec_ctl_decoder #(.NCH(NCH)) i_codec_ctl_decoder (.*);

  localparam logic [3:0] S_LAW = 1, S_DLY = 2, S_RXON = 3, S_TXON = 4, S_RXS = 5,
                         S_TXS = 6, S_IOIN = 7, S_LVL = 8, S_OE = 9, S_RXG = 10, S_TXG = 11;

  // {req, valid, byte, select, channel, expected}
  localparam logic [32:0] VEC [NV] = '{
    {4'd1,  1'b1, 8'h20, S_RXS,  2'd0, 14'd0},      // R1 stray data byte
    {4'd2,  1'b1, 8'hB7, S_LAW,  2'd0, 14'd1},      // R2 A-law, delay, ch1 both
    {4'd3,  1'b0, 8'h00, S_DLY,  2'd0, 14'd1},      // R3
    {4'd5,  1'b1, 8'h15, S_RXS,  2'd1, 14'd21},     // R5
    {4'd5,  1'b0, 8'h00, S_TXS,  2'd1, 14'd21},     // R5
    {4'd1,  1'b1, 8'h33, S_RXS,  2'd1, 14'd21},     // R1 second data byte
    {4'd4,  1'b0, 8'h00, S_RXON, 2'd1, 14'd1},      // R4
    {4'd2,  1'b1, 8'h8A, S_LAW,  2'd0, 14'd0},      // R2 mu-law, ch2 tx
    {4'd12, 1'b0, 8'hB7, S_LAW,  2'd0, 14'd0},      // R12 byte without strobe
    {4'd5,  1'b1, 8'h7F, S_TXS,  2'd2, 14'd127},    // R5
    {4'd5,  1'b0, 8'h00, S_RXS,  2'd2, 14'd0},      // R5 rx slot untouched
    {4'd4,  1'b0, 8'h00, S_RXON, 2'd2, 14'd0},      // R4
    {4'd4,  1'b0, 8'h00, S_TXON, 2'd2, 14'd1},      // R4
    {4'd4,  1'b1, 8'h84, S_RXON, 2'd1, 14'd0},      // R4 power down ch1
    {4'd1,  1'b1, 8'h05, S_RXS,  2'd1, 14'd21},     // R1 nothing pending
    {4'd6,  1'b1, 8'hDE, S_IOIN, 2'd3, 14'd2},      // R6
    {4'd7,  1'b0, 8'h00, S_OE,   2'd3, 14'd29},     // R7
    {4'd7,  1'b1, 8'h7F, S_LVL,  2'd3, 14'd29},     // R7
    {4'd3,  1'b1, 8'hC3, S_DLY,  2'd0, 14'd0},      // R3 gain cfg keeps timing
    {4'd8,  1'b1, 8'h55, S_TXG,  2'd0, 14'h2A80},   // R8 upper half
    {4'd8,  1'b1, 8'hC2, S_RXG,  2'd0, 14'd0},      // R8
    {4'd8,  1'b1, 8'h2A, S_TXG,  2'd0, 14'h2AAA},   // R8 lower half
    {4'd9,  1'b1, 8'hC0, S_RXG,  2'd0, 14'd0},      // R9 setup
    {4'd9,  1'b1, 8'hE3, S_LAW,  2'd0, 14'd0},      // R9 reserved
    {4'd9,  1'b1, 8'h11, S_RXG,  2'd0, 14'd0},      // R9 pending cancelled
    {4'd4,  1'b1, 8'h81, S_RXON, 2'd0, 14'd1},      // R4
    {4'd10, 1'b1, 8'hC1, S_RXS,  2'd0, 14'd0},      // R10 replaces slot cmd
    {4'd10, 1'b1, 8'h03, S_RXG,  2'd0, 14'h0180},   // R10
    {4'd10, 1'b0, 8'h00, S_RXS,  2'd0, 14'd0}       // R10
  };

  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [13:0] pick(input logic [3:0] s, input int c);
    case (s)
      S_LAW:  return 14'(law_alaw);
      S_DLY:  return 14'(frame_delay);
      S_RXON: return 14'(rx_on[c]);
      S_TXON: return 14'(tx_on[c]);
      S_RXS:  return 14'(rx_slot[c*7 +: 7]);
      S_TXS:  return 14'(tx_slot[c*7 +: 7]);
      S_IOIN: return 14'(io_is_input[c*2 +: 2]);
      S_LVL:  return 14'(pin_level[c*5 +: 5]);
      S_OE:   return 14'(pin_oe[c*5 +: 5]);
      S_RXG:  return rx_gain[c*14 +: 14];
      S_TXG:  return tx_gain[c*14 +: 14];
      default: return 14'd0;
    endcase
  endfunction

  task automatic check(input int req, input logic [3:0] s, input int c, input logic [13:0] exp);
    logic [13:0] act;
    act = pick(s, c);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d sel %0d ch %0d: actual %h expected %h", req, s, c, act, exp);
    end
  endtask

  task automatic reset_checks;
    for (int c = 0; c < NCH; c++) begin
      check(11, S_RXON, c, 0);   // R11
      check(11, S_TXON, c, 0);
      check(11, S_IOIN, c, 3);
      check(11, S_OE,   c, 14'h1C);
      check(11, S_RXG,  c, 0);
      check(11, S_TXG,  c, 0);
      check(11, S_TXS,  c, 0);
    end
    check(11, S_LAW, 0, 0);
    check(11, S_DLY, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    reset_checks();
    for (int i = 0; i < NV; i++) begin
      byte_valid = VEC[i][28];
      byte_data  = VEC[i][27:20];
      @(negedge clk);
      byte_valid = 1'b0;
      check(int'(VEC[i][32:29]), VEC[i][19:16], int'(VEC[i][15:14]), VEC[i][13:0]);
    end
    // R11: a mid-run reset returns the programmed state to its defaults
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    reset_checks();
    // R1: after the reset nothing is pending, so a data byte is ignored
    byte_valid = 1'b1;
    byte_data  = 8'h44;
    @(negedge clk);
    byte_valid = 1'b0;
    check(1, S_RXS, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule